// File: doc/BRIEF.md
# Boot Mode Status LED Driver

This block drives two board indicator LEDs, one green and one red, from board state and two 4-bit selector fields. Right after power-on it samples the boot-mode strap pin once and keeps that value until the next power-on. Later resets driven by the reset input or by the power-good and power-on-done signals do not sample it again. The red LED then blinks a pattern that identifies the boot source. While the power-enable input is low, the red LED shows a slower, short-pulse pattern instead. While the board is held in reset, both LEDs are lit.

Outside those hardware conditions, each LED follows its selector. A selector can route one of three PHY LED lines, the GPIO input or the RTC interrupt to the LED, or it can force the LED off or on. A selector code that has no listed meaning falls back to a default: the boot-mode blink for red, the GPIO input for green. When the watchdog is enabled, the green LED shows a watchdog counter bit and ignores its selector. All blink timing comes from a prescaler on the system clock that produces sixteen ticks per second. A simulation parameter can shorten the prescaler.

The control is a four-state machine:
- CAPTURE is entered at power-on and samples the boot pin.
- NO_POWER is used while power enable is low.
- HOLD is used while any reset source is active.
- RUN is the normal state.

From every state the next state follows the same priority. If power enable is low, the next state is NO_POWER. Otherwise, if any reset source is active, it is HOLD. Otherwise it is RUN. CAPTURE is re-entered only through the power-on reset.

Top module: `boot_led_driver`

## Requirements
- R1: The boot pin is sampled only in the first clock cycle after `por_n` is released. Changing the boot pin later, or asserting any soft reset source, leaves the boot blink unchanged until the next power-on.
- R2: In RUN with the red selector at its default, the red LED shows the boot blink. A latched boot pin of 1 gives 4 Hz (on for 2 ticks, off for 2 ticks). A latched boot pin of 0 (SD card boot) gives 1 Hz (on for 8 ticks, off for 8 ticks).
- R3: While `pwr_en` is low, the red LED blinks at 0.5 Hz with 1/8 duty: on for 4 ticks out of every 32. This takes priority over reset and over the selector.
- R4: While the reset condition is active, and during `por_n` low, both LEDs are on. The one exception is the red LED while `pwr_en` is low (R3). The green LED is on whenever `pwr_en` is low.
- R5: The reset condition is active when any of `pwr_en`, `rst_in_n`, `pg_all` or `pon_done` is low.
- R6: In RUN, the selector codes mean:

  | Code | LED |
  |---|---|
  | 0001 | `phy_led[0]` |
  | 0010 | `phy_led[1]` |
  | 0011 | `phy_led[2]` |
  | 0100 | `gpio_in` |
  | 0101 | `rtc_irq` |
  | 0110 | off |
  | 0111 | on |

  The same codes apply to both LEDs.
- R7: Any other selector code, including 0000, selects the boot blink for the red LED and `gpio_in` for the green LED.
- R8: In RUN with `wdt_en` high, the green LED equals `wdt_bit`, whatever the green selector holds.
- R9: One tick lasts `TICK_CYCLES` clocks. `TICK_CYCLES` is `CLK_HZ/16`, unless `SIM_TICK_CYCLES` is nonzero, in which case it replaces that value.
- R10: The LEDs respond to `pwr_en` and to the reset sources one clock after the input changes. Selector and source inputs reach the LEDs combinationally in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pwr_en | input | 1 | Debounced power-enable input |
| rst_in_n | input | 1 | Reset input, active low |
| pg_all | input | 1 | Combined power-good |
| pon_done | input | 1 | Power-on-done signal |
| boot_pin | input | 1 | Boot-mode strap; low selects SD card boot |
| wdt_en | input | 1 | Watchdog enabled |
| wdt_bit | input | 1 | Watchdog counter bit 7 |
| phy_led | input | 3 | PHY LED lines 0..2 |
| gpio_in | input | 1 | GPIO input |
| rtc_irq | input | 1 | RTC interrupt line |
| sel_green | input | 4 | Green LED selector |
| sel_red | input | 4 | Red LED selector |
| led_green | output | 1 | Green LED drive |
| led_red | output | 1 | Red LED drive |

## Verification
The bench counts on-cycles and toggles over exactly 128 clocks, which is 32 ticks with the shortened prescaler. Over that window the 4 Hz and 1 Hz patterns both have 64 on-cycles and differ only in toggle count (16 against 4). The power-low pattern gives 16 on-cycles and 2 toggles, so a wrong divider tap or a wrong duty decode shows up as a count mismatch.

The bench changes the boot pin after power-on and asserts a soft reset. A design that samples the pin again would switch the blink rate. The bench also holds power enable low while reset is active and while the red selector forces the LED on. A design that ordered the priorities wrongly would then show a steady LED instead of the short pulses.

The bench walks through every listed selector code under two opposite source patterns, and also applies an unlisted code. This catches a swapped mux leg and a wrong default on either LED.

// File: rtl/boot_led_pkg.sv
package boot_led_pkg;

    typedef enum logic [1:0] {
        ST_CAPTURE  = 2'd0,
        ST_NO_POWER = 2'd1,
        ST_HOLD     = 2'd2,
        ST_RUN      = 2'd3
    } led_state_e;

    localparam logic [3:0] SEL_PHY0 = 4'b0001;
    localparam logic [3:0] SEL_PHY1 = 4'b0010;
    localparam logic [3:0] SEL_PHY2 = 4'b0011;
    localparam logic [3:0] SEL_GPIO = 4'b0100;
    localparam logic [3:0] SEL_RTC  = 4'b0101;
    localparam logic [3:0] SEL_OFF  = 4'b0110;
    localparam logic [3:0] SEL_ON   = 4'b0111;

    typedef struct packed {
        logic [2:0] phy;
        logic       gpio;
        logic       rtc;
    } led_src_t;

endpackage

// File: rtl/led_blink_gen.sv
module led_blink_gen #(
    parameter int TICK_CYCLES = 1562500
) (
    input  logic clk,
    input  logic por_n,
    output logic blink_4hz,
    output logic blink_1hz,
    output logic blink_nopwr
);
    localparam int CNT_W   = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam int PHASE_W = 5;
    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(TICK_CYCLES - 1);

    logic [CNT_W-1:0]   pre_q;
    logic [PHASE_W-1:0] phase_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pre_q   <= '0;
            phase_q <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q   <= '0;
            phase_q <= phase_q + 1'b1;
        end else begin
            pre_q   <= pre_q + 1'b1;
        end
    end

    // 4 ticks per period, 16 per period, and 4 of 32 on
    assign blink_4hz   = ~phase_q[1];
    assign blink_1hz   = ~phase_q[3];
    assign blink_nopwr = (phase_q[4:2] == 3'b000);

endmodule

// File: rtl/led_state_fsm.sv
module led_state_fsm
    import boot_led_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       pwr_en,
    input  logic       rst_in_n,
    input  logic       pg_all,
    input  logic       pon_done,
    input  logic       boot_pin,
    output led_state_e state,
    output logic       boot_sd
);
    led_state_e state_q, state_d, pick;
    logic       hold_cond;

    assign hold_cond = !(pwr_en && rst_in_n && pg_all && pon_done);
    assign pick = !pwr_en  ? ST_NO_POWER :
                  hold_cond ? ST_HOLD     : ST_RUN;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_CAPTURE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_CAPTURE:  state_d = pick;   // strap sampled, leave capture
            ST_NO_POWER: state_d = pick;   // power back -> HOLD or RUN
            ST_HOLD:     state_d = pick;   // reset released -> RUN
            ST_RUN:      state_d = pick;   // power low / reset -> leave
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                    boot_sd <= 1'b0;
        else if (state_q == ST_CAPTURE) boot_sd <= !boot_pin;
    end

    assign state = state_q;

endmodule

// File: rtl/led_src_mux.sv
module led_src_mux
    import boot_led_pkg::*;
(
    input  logic [3:0] sel,
    input  led_src_t   src,
    input  logic       dflt,
    output logic       led
);
    always_comb begin
        case (sel)
            SEL_PHY0: led = src.phy[0];
            SEL_PHY1: led = src.phy[1];
            SEL_PHY2: led = src.phy[2];
            SEL_GPIO: led = src.gpio;
            SEL_RTC:  led = src.rtc;
            SEL_OFF:  led = 1'b0;
            SEL_ON:   led = 1'b1;
            default:  led = dflt;
        endcase
    end

endmodule

// File: rtl/boot_led_driver.sv
module boot_led_driver
    import boot_led_pkg::*;
#(
    parameter int CLK_HZ          = 25000000,
    parameter int SIM_TICK_CYCLES = 0
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       pwr_en,
    input  logic       rst_in_n,
    input  logic       pg_all,
    input  logic       pon_done,
    input  logic       boot_pin,
    input  logic       wdt_en,
    input  logic       wdt_bit,
    input  logic [2:0] phy_led,
    input  logic       gpio_in,
    input  logic       rtc_irq,
    input  logic [3:0] sel_green,
    input  logic [3:0] sel_red,
    output logic       led_green,
    output logic       led_red
);
    localparam int TICK_CYCLES = (SIM_TICK_CYCLES > 0) ? SIM_TICK_CYCLES : CLK_HZ / 16;
    localparam int N_LED = 2;   // index 0 green, 1 red

    led_state_e state;
    logic       boot_sd;
    logic       b4, b1, bnp, boot_blink;
    led_src_t   src;
    logic [N_LED-1:0] mux_out;
    logic [N_LED-1:0] dflt;
    logic [3:0]       sel [N_LED];

    led_blink_gen #(.TICK_CYCLES(TICK_CYCLES)) u_blink (
        .clk(clk), .por_n(por_n),
        .blink_4hz(b4), .blink_1hz(b1), .blink_nopwr(bnp)
    );

    led_state_fsm u_fsm (
        .clk(clk), .por_n(por_n), .pwr_en(pwr_en), .rst_in_n(rst_in_n),
        .pg_all(pg_all), .pon_done(pon_done), .boot_pin(boot_pin),
        .state(state), .boot_sd(boot_sd)
    );

    assign boot_blink = boot_sd ? b1 : b4;
    assign src        = '{phy: phy_led, gpio: gpio_in, rtc: rtc_irq};
    assign dflt       = {boot_blink, gpio_in};
    assign sel[0]     = sel_green;
    assign sel[1]     = sel_red;

    for (genvar i = 0; i < N_LED; i++) begin : g_mux
        led_src_mux u_mux (
            .sel(sel[i]), .src(src), .dflt(dflt[i]), .led(mux_out[i])
        );
    end

    always_comb begin
        unique case (state)
            ST_CAPTURE:  begin led_green = 1'b1; led_red = 1'b1;  end
            ST_NO_POWER: begin led_green = 1'b1; led_red = bnp;   end
            ST_HOLD:     begin led_green = 1'b1; led_red = 1'b1;  end
            ST_RUN:      begin
                led_green = wdt_en ? wdt_bit : mux_out[0];
                led_red   = mux_out[1];
            end
        endcase
    end

endmodule

// File: rtl/boot_led_checker.sv
module boot_led_checker
    import boot_led_pkg::*;
(
    input logic       clk,
    input logic       por_n,
    input logic       pwr_en,
    input logic       rst_in_n,
    input logic       pg_all,
    input logic       pon_done,
    input logic       wdt_en,
    input logic       wdt_bit,
    input logic [3:0] sel_red,
    input logic       led_green,
    input logic       led_red,
    input led_state_e state,
    input logic       boot_sd
);
    AST_BOOT_HELD: assert property (@(posedge clk) disable iff (!por_n)
        (state != ST_CAPTURE) |=> $stable(boot_sd)); // R1

    AST_NOPWR_STATE: assert property (@(posedge clk) disable iff (!por_n)
        !pwr_en |=> (state == ST_NO_POWER)); // R3

    AST_NOPWR_GREEN_ON: assert property (@(posedge clk) disable iff (!por_n)
        !pwr_en |=> led_green); // R4

    AST_RESET_BOTH_ON: assert property (@(posedge clk) disable iff (!por_n)
        (pwr_en && !(rst_in_n && pg_all && pon_done)) |=> (led_green && led_red)); // R5

    AST_FORCE_OFF_RED: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_RUN && sel_red == SEL_OFF) |-> !led_red); // R6

    AST_WDT_GREEN: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_RUN && wdt_en) |-> (led_green == wdt_bit)); // R8

endmodule

bind boot_led_driver boot_led_checker u_chk (
    .clk(clk), .por_n(por_n), .pwr_en(pwr_en), .rst_in_n(rst_in_n),
    .pg_all(pg_all), .pon_done(pon_done), .wdt_en(wdt_en), .wdt_bit(wdt_bit),
    .sel_red(sel_red), .led_green(led_green), .led_red(led_red),
    .state(state), .boot_sd(boot_sd)
);

// File: tb/boot_led_driver_test.sv
module boot_led_driver_test;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       pwr_en = 1'b1, rst_in_n = 1'b1, pg_all = 1'b1, pon_done = 1'b1;
    logic       boot_pin = 1'b0, wdt_en = 1'b0, wdt_bit = 1'b0;
    logic [2:0] phy_led = 3'b000;
    logic       gpio_in = 1'b0, rtc_irq = 1'b0;
    logic [3:0] sel_green = 4'd0, sel_red = 4'd0;
    logic       led_green, led_red;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    boot_led_driver #(.CLK_HZ(100000000), .SIM_TICK_CYCLES(4)) uut (
        .clk(clk), .por_n(por_n), .pwr_en(pwr_en), .rst_in_n(rst_in_n),
        .pg_all(pg_all), .pon_done(pon_done), .boot_pin(boot_pin),
        .wdt_en(wdt_en), .wdt_bit(wdt_bit), .phy_led(phy_led),
        .gpio_in(gpio_in), .rtc_irq(rtc_irq), .sel_green(sel_green),
        .sel_red(sel_red), .led_green(led_green), .led_red(led_red)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    // 128 clocks = 32 ticks of 4 clocks each
    task automatic measure_red(output int on_cnt, output int tog);
        logic prev;
        on_cnt = 0; tog = 0;
        @(negedge clk); prev = led_red;
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            on_cnt += int'(led_red);
            if (led_red != prev) tog++;
            prev = led_red;
        end
    endtask

    task automatic power_on(input logic pin);
        @(negedge clk);
        por_n = 1'b0; boot_pin = pin;
        repeat (3) @(negedge clk);
        check("R4 green on during power-on reset", int'(led_green), 1);
        check("R4 red on during power-on reset", int'(led_red), 1);
        por_n = 1'b1;
        settle();
    endtask

    task automatic t_sd_boot();
        int on_c, tg;
        power_on(1'b0);
        boot_pin = 1'b1;   // later change must be ignored (R1)
        measure_red(on_c, tg);
        check("R2 R9 sd blink on-count", on_c, 64);
        check("R2 R9 sd blink toggles", tg, 4);
        gpio_in = 1'b1; #1;
        check("R7 green default follows gpio=1", int'(led_green), 1);
        gpio_in = 1'b0; #1;
        check("R7 green default follows gpio=0", int'(led_green), 0);
    endtask

    function automatic logic exp_sel(input logic [3:0] c);
        case (c)
            4'd1: return phy_led[0];
            4'd2: return phy_led[1];
            4'd3: return phy_led[2];
            4'd4: return gpio_in;
            4'd5: return rtc_irq;
            4'd6: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic t_selectors();
        int on_c, tg;
        for (int p = 0; p < 2; p++) begin
            phy_led = (p == 0) ? 3'b101 : 3'b010;
            gpio_in = (p == 0) ? 1'b0 : 1'b1;
            rtc_irq = (p == 0) ? 1'b1 : 1'b0;
            for (int c = 1; c <= 7; c++) begin
                sel_green = 4'(c); sel_red = 4'(c); #1;
                check($sformatf("R6 green code %0d", c), int'(led_green), int'(exp_sel(4'(c))));
                check($sformatf("R6 red code %0d", c), int'(led_red), int'(exp_sel(4'(c))));
            end
        end
        sel_green = 4'b1010; gpio_in = 1'b1; #1;
        check("R7 green unlisted code gives gpio", int'(led_green), 1);
        sel_red = 4'b1010;
        measure_red(on_c, tg);
        check("R7 red unlisted code gives boot blink", tg, 4);
        sel_red = 4'd0; sel_green = 4'd0; gpio_in = 1'b0;
    endtask

    task automatic t_soft_reset();
        int on_c, tg;
        sel_green = 4'd6; sel_red = 4'd6;
        @(negedge clk); rst_in_n = 1'b0;
        @(negedge clk);
        check("R10 R5 reset input: green on after one clock", int'(led_green), 1);
        check("R5 reset input: red on", int'(led_red), 1);
        rst_in_n = 1'b1; pg_all = 1'b0; settle();
        check("R5 power-good low: both on", int'(led_green & led_red), 1);
        pg_all = 1'b1; pon_done = 1'b0; settle();
        check("R5 power-on-done low: both on", int'(led_green & led_red), 1);
        pon_done = 1'b1; settle();
        check("R6 after reset released red forced off", int'(led_red), 0);
        sel_red = 4'd0; sel_green = 4'd0;
        measure_red(on_c, tg);
        check("R1 soft reset keeps sd blink", tg, 4);
    endtask

    task automatic t_no_power();
        int on_c, tg;
        pwr_en = 1'b0; settle();
        measure_red(on_c, tg);
        check("R3 power-low on-count", on_c, 16);
        check("R3 power-low toggles", tg, 2);
        check("R4 green on while power low", int'(led_green), 1);
        rst_in_n = 1'b0; sel_red = 4'd7; settle();
        measure_red(on_c, tg);
        check("R3 power-low beats reset and selector", on_c, 16);
        rst_in_n = 1'b1; sel_red = 4'd0; pwr_en = 1'b1; settle();
    endtask

    task automatic t_watchdog();
        sel_green = 4'd7; wdt_en = 1'b1; wdt_bit = 1'b0; #1;
        check("R8 wdt bit 0 overrides force-on", int'(led_green), 0);
        wdt_bit = 1'b1; #1;
        check("R8 wdt bit 1 shown", int'(led_green), 1);
        wdt_bit = 1'b0; rst_in_n = 1'b0; settle();
        check("R4 reset beats watchdog display", int'(led_green), 1);
        rst_in_n = 1'b1; settle();
        wdt_en = 1'b0; sel_green = 4'd6; #1;
        check("R6 watchdog off restores selector", int'(led_green), 0);
        sel_green = 4'd0;
    endtask

    task automatic t_qspi_boot();
        int on_c, tg;
        power_on(1'b1);
        measure_red(on_c, tg);
        check("R2 R9 qspi blink on-count", on_c, 64);
        check("R2 R9 qspi blink toggles", tg, 16);
        boot_pin = 1'b0; settle();
        measure_red(on_c, tg);
        check("R1 qspi kept after strap change", tg, 16);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_sd_boot();
        t_selectors();
        t_soft_reset();
        t_no_power();
        t_watchdog();
        t_qspi_boot();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule